// File: doc/BRIEF.md
# Profile-Pin Modulation Word Selector

This block sits in front of a two-channel waveform synthesizer. It samples four external profile pins and picks, for each channel, one stored channel word. Configuration fields decide how that choice is made: the kind of modulation, the number of levels, which pins are reserved for ramp control, and how the pins are split between the channels. The chosen word goes to the amplitude, frequency or phase output of its channel. The other two outputs of that channel keep the channel's base word, which is word 0.

The pins and two serial ramp lines are asynchronous to the core clock. They pass through a two-flop synchronizer, and every output is registered. When some pins are reserved for ramping, they produce a ramp enable and a ramp direction for each channel. The word banks and the configuration fields are plain inputs that the surrounding logic holds steady. There is no stream traffic and no handshake, so nothing here back-pressures.

The block detects configurations it cannot serve and reports them on a sticky flag. Until the next reset it holds both channels on their base words.

Top module: `pmod_profile_select`

## Requirements
- R1: A change on `profile_pins` or `serial_ramp` appears at the outputs on the third rising clock edge after the change, and not on the second.
- R2: `mod_type` encodes 00 off, 01 amplitude, 10 frequency, 11 phase. When modulating, only the named output carries the selected word. The other two outputs of the channel carry word 0 (bank bits [WORD_W-1:0]).
- R3: With `mod_type` = 00, all three outputs of each channel carry that channel's word 0, whatever the pins are.
- R4: `mod_level` encodes 00 two, 01 four, 10 eight, 11 sixteen levels. In two-level mode, pin P2 (`profile_pins[2]`) alone gives the channel 0 word index (0 or 1), and P3 (`profile_pins[3]`) alone gives the channel 1 index.
- R5: In four-level mode with `pin_map` = 101, channel 0 uses the index {P0,P1} and channel 1 uses {P2,P3}, with P0 (`profile_pins[0]`) and P2 as the MSBs.
- R6: While `mod_type` is not 00, any of the following is an error: `sweep_en` = 1, level 10 or 11, four-level with `pin_map` other than 101, or `ramp_mode` 01 or 10. An error sets `config_error` on the next edge. The flag stays set until reset, and meanwhile every word output carries word 0.
- R7: `ramp_mode` encodes 00 off, 01 P2 and P3 reserved, 10 only P3 reserved, 11 serial lines. Mode 01: P2 gives the channel 0 direction and P3 the channel 1 direction. Mode 10: P3 gives the direction of both channels. Mode 11: `serial_ramp[0]` drives channel 0 and `serial_ramp[1]` drives channel 1. A value of 0 means ramp up and 1 means ramp down (`ramp_dn` bit n belongs to channel n). `ramp_en` is 11 in every mode except off, and in off mode both `ramp_en` and `ramp_dn` are 00.
- R8: `serial_1bit` is 1 exactly when `ramp_mode` is 11.
- R9: After reset, all outputs and `config_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| profile_pins | input | 4 | Profile pins; bit n is Pn |
| serial_ramp | input | 2 | Serial data lines used for ramp direction in mode 11 |
| mod_type | input | 2 | Modulation kind |
| mod_level | input | 2 | Number of levels |
| sweep_en | input | 1 | Linear sweep enable, must be 0 while modulating |
| ramp_mode | input | 2 | Ramp pin reservation |
| pin_map | input | 3 | Pin-to-channel assignment code |
| ch0_bank | input | WORD_W*NWORDS | Channel 0 words, word k at bits [k*WORD_W +: WORD_W] |
| ch1_bank | input | WORD_W*NWORDS | Channel 1 words, same layout |
| ch0_amp | output | WORD_W | Channel 0 amplitude word |
| ch0_freq | output | WORD_W | Channel 0 frequency word |
| ch0_phase | output | WORD_W | Channel 0 phase word |
| ch1_amp | output | WORD_W | Channel 1 amplitude word |
| ch1_freq | output | WORD_W | Channel 1 frequency word |
| ch1_phase | output | WORD_W | Channel 1 phase word |
| ramp_en | output | 2 | Per-channel ramp enable |
| ramp_dn | output | 2 | Per-channel ramp direction, 1 = down |
| serial_1bit | output | 1 | Serial port forced to 1-bit mode |
| config_error | output | 1 | Sticky unsupported-configuration flag |

## Verification
A fault in the synchronizer chain shows up at once as a word index that settles one edge early or late. A flipped or swapped bit in the index decode sends a neighbouring bank word to the named output on the third edge after the pins move. An error flag that clears or never sets is visible on the next edge: `config_error` is wrong, and word outputs that should sit on word 0 instead follow the pins. Because every bank word in the bench is distinct and tagged by channel, any misrouting between channels, outputs or indices gives a value that cannot be mistaken for the correct one.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
  typedef enum logic [1:0] {
    MOD_OFF   = 2'b00,
    MOD_AMP   = 2'b01,
    MOD_FREQ  = 2'b10,
    MOD_PHASE = 2'b11
  } mod_kind_e;

  typedef enum logic [1:0] {
    LVL_2  = 2'b00,
    LVL_4  = 2'b01,
    LVL_8  = 2'b10,
    LVL_16 = 2'b11
  } mod_level_e;

  typedef enum logic [1:0] {
    RAMP_OFF    = 2'b00,
    RAMP_P2P3   = 2'b01,
    RAMP_P3     = 2'b10,
    RAMP_SERIAL = 2'b11
  } ramp_mode_e;

  localparam logic [2:0] PINMAP_SPLIT = 3'b101;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/pmod_sync.sv
module pmod_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pmod_index_decode.sv
module pmod_index_decode
  import pmod_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [3:0]       pins,
  input  logic [1:0]       serial,
  input  mod_kind_e        kind,
  input  mod_level_e       level,
  input  logic             sweep_en,
  input  ramp_mode_e       rmode,
  input  logic [2:0]       pin_map,
  output logic [IDX_W-1:0] idx0,
  output logic [IDX_W-1:0] idx1,
  output logic             cfg_bad,
  output logic [1:0]       ramp_en,
  output logic [1:0]       ramp_dn
);
  always_comb begin
    idx0    = '0;
    idx1    = '0;
    cfg_bad = 1'b0;
    if (kind != MOD_OFF) begin
      if (sweep_en) cfg_bad = 1'b1;
      if (rmode == RAMP_P2P3 || rmode == RAMP_P3) cfg_bad = 1'b1;
      case (level)
        LVL_2: begin
          idx0[0] = pins[2];
          idx1[0] = pins[3];
        end
        LVL_4: begin
          if (pin_map == PINMAP_SPLIT) begin
            idx0[1:0] = {pins[0], pins[1]};
            idx1[1:0] = {pins[2], pins[3]};
          end else begin
            cfg_bad = 1'b1;
          end
        end
        default: cfg_bad = 1'b1;
      endcase
    end
  end

  always_comb begin
    ramp_en = 2'b00;
    ramp_dn = 2'b00;
    case (rmode)
      RAMP_P2P3: begin
        ramp_en = 2'b11;
        ramp_dn = {pins[3], pins[2]};
      end
      RAMP_P3: begin
        ramp_en = 2'b11;
        ramp_dn = {pins[3], pins[3]};
      end
      RAMP_SERIAL: begin
        ramp_en = 2'b11;
        ramp_dn = serial;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmod_word_route.sv
module pmod_word_route
  import pmod_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NWORDS = 16,
  localparam int IDX_W  = $clog2(NWORDS),
  localparam int BANK_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  input  logic              force_base,
  input  mod_kind_e         kind,
  output logic [WORD_W-1:0] amp_q,
  output logic [WORD_W-1:0] freq_q,
  output logic [WORD_W-1:0] phase_q
);
  logic [WORD_W-1:0] base_w, sel_w, pick_w;

  assign base_w = bank[WORD_W-1:0];
  assign sel_w  = bank[int'(idx)*WORD_W +: WORD_W];
  assign pick_w = force_base ? base_w : sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q   <= '0;
      freq_q  <= '0;
      phase_q <= '0;
    end else begin
      amp_q   <= (kind == MOD_AMP)   ? pick_w : base_w;
      freq_q  <= (kind == MOD_FREQ)  ? pick_w : base_w;
      phase_q <= (kind == MOD_PHASE) ? pick_w : base_w;
    end
  end

  // R3 / R6: a forced channel shows its base word on all outputs
  assert_base_on_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_base |=> (amp_q == $past(base_w)) && (freq_q == $past(base_w)) &&
                   (phase_q == $past(base_w)));

  // R2: amplitude modulation leaves the other two outputs on word 0
  assert_unrouted_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == MOD_AMP) |=> (freq_q == $past(base_w)) && (phase_q == $past(base_w)));
endmodule

// File: rtl/pmod_profile_select.sv
module pmod_profile_select
  import pmod_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NWORDS = 16,
  localparam int IDX_W  = $clog2(NWORDS),
  localparam int BANK_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        profile_pins,
  input  logic [1:0]        serial_ramp,
  input  logic [1:0]        mod_type,
  input  logic [1:0]        mod_level,
  input  logic              sweep_en,
  input  logic [1:0]        ramp_mode,
  input  logic [2:0]        pin_map,
  input  logic [BANK_W-1:0] ch0_bank,
  input  logic [BANK_W-1:0] ch1_bank,
  output logic [WORD_W-1:0] ch0_amp,
  output logic [WORD_W-1:0] ch0_freq,
  output logic [WORD_W-1:0] ch0_phase,
  output logic [WORD_W-1:0] ch1_amp,
  output logic [WORD_W-1:0] ch1_freq,
  output logic [WORD_W-1:0] ch1_phase,
  output logic [1:0]        ramp_en,
  output logic [1:0]        ramp_dn,
  output logic              serial_1bit,
  output logic              config_error
);
  localparam int SYNC_W = 6;

  mod_kind_e  kind;
  mod_level_e level;
  ramp_mode_e rmode;
  assign kind  = mod_kind_e'(mod_type);
  assign level = mod_level_e'(mod_level);
  assign rmode = ramp_mode_e'(ramp_mode);

  logic [SYNC_W-1:0] sync_q;
  logic [3:0]        pins_s;
  logic [1:0]        serial_s;

  pmod_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({serial_ramp, profile_pins}),
    .q_sync  (sync_q)
  );
  assign pins_s   = sync_q[3:0];
  assign serial_s = sync_q[5:4];

  logic [IDX_W-1:0] idx [NUM_CH];
  logic             cfg_bad;
  logic [1:0]       ramp_en_d, ramp_dn_d;

  pmod_index_decode #(.IDX_W(IDX_W)) u_dec (
    .pins     (pins_s),
    .serial   (serial_s),
    .kind     (kind),
    .level    (level),
    .sweep_en (sweep_en),
    .rmode    (rmode),
    .pin_map  (pin_map),
    .idx0     (idx[0]),
    .idx1     (idx[1]),
    .cfg_bad  (cfg_bad),
    .ramp_en  (ramp_en_d),
    .ramp_dn  (ramp_dn_d)
  );

  logic err_q;
  logic force_base;
  assign force_base = cfg_bad | err_q | (kind == MOD_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q       <= 1'b0;
      ramp_en     <= 2'b00;
      ramp_dn     <= 2'b00;
      serial_1bit <= 1'b0;
    end else begin
      err_q       <= err_q | cfg_bad;
      ramp_en     <= ramp_en_d;
      ramp_dn     <= ramp_dn_d;
      serial_1bit <= (rmode == RAMP_SERIAL);
    end
  end
  assign config_error = err_q;

  logic [BANK_W-1:0] bank_w  [NUM_CH];
  logic [WORD_W-1:0] amp_w   [NUM_CH];
  logic [WORD_W-1:0] freq_w  [NUM_CH];
  logic [WORD_W-1:0] phase_w [NUM_CH];
  assign bank_w[0] = ch0_bank;
  assign bank_w[1] = ch1_bank;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pmod_word_route #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank       (bank_w[c]),
      .idx        (idx[c]),
      .force_base (force_base),
      .kind       (kind),
      .amp_q      (amp_w[c]),
      .freq_q     (freq_w[c]),
      .phase_q    (phase_w[c])
    );
  end

  assign ch0_amp   = amp_w[0];
  assign ch0_freq  = freq_w[0];
  assign ch0_phase = phase_w[0];
  assign ch1_amp   = amp_w[1];
  assign ch1_freq  = freq_w[1];
  assign ch1_phase = phase_w[1];

  // R6: once raised, the error flag stays until reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);

  // R6: sweep enable while modulating raises the flag on the next edge
  assert_sweep_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && mod_type != 2'b00) |=> config_error);

  // R7: ramp mode off clears both ramp outputs
  assert_ramp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mode == 2'b00) |=> (ramp_en == 2'b00) && (ramp_dn == 2'b00));

  // R8: serial ramp mode forces the 1-bit serial flag
  assert_serial_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mode == 2'b11) |=> serial_1bit);
endmodule

// File: tb/pmod_profile_select_tb.sv
`timescale 1ns/1ps
module pmod_profile_select_tb;
  localparam int WORD_W = 16;
  localparam int NWORDS = 16;
  localparam int BANK_W = WORD_W * NWORDS;

  typedef struct packed {
    logic [WORD_W-1:0] c0a, c0f, c0p, c1a, c1f, c1p;
    logic [1:0] ren, rdn;
    logic s1b, err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = 4'b0;
  logic [1:0] ser = 2'b0;
  logic [1:0] mtype = 2'b0, mlevel = 2'b0, rmode = 2'b0;
  logic sweep = 1'b0;
  logic [2:0] pmap = 3'b0;
  logic [BANK_W-1:0] bank0, bank1;
  logic [WORD_W-1:0] c0a, c0f, c0p, c1a, c1f, c1p;
  logic [1:0] ren, rdn;
  logic s1b, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit err_model = 0;
  exp_t exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pmod_profile_select #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .profile_pins(pins), .serial_ramp(ser),
    .mod_type(mtype), .mod_level(mlevel), .sweep_en(sweep), .ramp_mode(rmode),
    .pin_map(pmap), .ch0_bank(bank0), .ch1_bank(bank1),
    .ch0_amp(c0a), .ch0_freq(c0f), .ch0_phase(c0p),
    .ch1_amp(c1a), .ch1_freq(c1f), .ch1_phase(c1p),
    .ramp_en(ren), .ramp_dn(rdn), .serial_1bit(s1b), .config_error(err));

  function automatic logic [WORD_W-1:0] w0(int k); return 16'hA000 + 16'(k); endfunction
  function automatic logic [WORD_W-1:0] w1(int k); return 16'hB000 + 16'(k); endfunction

  task automatic chk(input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    bit bad;
    int i0, i1;
    logic [WORD_W-1:0] s0, s1;
    bad = (mtype != 0) && (sweep || mlevel >= 2 || (mlevel == 1 && pmap != 3'b101) ||
                           rmode == 1 || rmode == 2);
    err_model = err_model | bad;
    i0 = 0; i1 = 0;
    if (mtype != 0 && !err_model) begin
      if (mlevel == 0) begin i0 = int'(pins[2]); i1 = int'(pins[3]); end
      else begin i0 = 2*int'(pins[0]) + int'(pins[1]); i1 = 2*int'(pins[2]) + int'(pins[3]); end
    end
    s0 = w0(i0); s1 = w1(i1);
    e.c0a = (mtype == 1) ? s0 : w0(0);
    e.c0f = (mtype == 2) ? s0 : w0(0);
    e.c0p = (mtype == 3) ? s0 : w0(0);
    e.c1a = (mtype == 1) ? s1 : w1(0);
    e.c1f = (mtype == 2) ? s1 : w1(0);
    e.c1p = (mtype == 3) ? s1 : w1(0);
    case (rmode)
      2'd1: begin e.ren = 2'b11; e.rdn = {pins[3], pins[2]}; end
      2'd2: begin e.ren = 2'b11; e.rdn = {pins[3], pins[3]}; end
      2'd3: begin e.ren = 2'b11; e.rdn = ser; end
      default: begin e.ren = 2'b00; e.rdn = 2'b00; end
    endcase
    e.s1b = (rmode == 3);
    e.err = err_model;
    return e;
  endfunction

  // driver: called at a falling edge
  task automatic apply(input logic [1:0] t, input logic [1:0] l, input logic sw,
                       input logic [1:0] r, input logic [2:0] m, input logic [3:0] p,
                       input logic [1:0] s, input string tag);
    mtype = t; mlevel = l; sweep = sw; rmode = r; pmap = m; pins = p; ser = s;
    repeat (3) @(posedge clk);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk(c0a, e.c0a, {tg, " ch0 amp"});
      chk(c0f, e.c0f, {tg, " ch0 freq"});
      chk(c0p, e.c0p, {tg, " ch0 phase"});
      chk(c1a, e.c1a, {tg, " ch1 amp"});
      chk(c1f, e.c1f, {tg, " ch1 freq"});
      chk(c1p, e.c1p, {tg, " ch1 phase"});
      chk(16'(ren), 16'(e.ren), {tg, " ramp_en"});
      chk(16'(rdn), 16'(e.rdn), {tg, " ramp_dn"});
      chk(16'(s1b), 16'(e.s1b), {tg, " serial_1bit"});
      chk(16'(err), 16'(e.err), {tg, " config_error"});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mtype = 0; mlevel = 0; sweep = 0; rmode = 0; pmap = 0; pins = 0; ser = 0;
    err_model = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < NWORDS; k++) begin
      bank0[k*WORD_W +: WORD_W] = w0(k);
      bank1[k*WORD_W +: WORD_W] = w1(k);
    end
    repeat (2) @(negedge clk);
    // R9: reset state
    chk(c0a | c0f | c0p | c1a | c1f | c1p, 16'h0, "R9 words in reset");
    chk(16'({ren, rdn, s1b, err}), 16'h0, "R9 flags in reset");
    rst_n = 1'b1;
    @(negedge clk);

    apply(2'd0, 2'd0, 0, 2'd0, 3'd0, 4'b1111, 2'b00, "R3 off");
    apply(2'd2, 2'd0, 0, 2'd0, 3'd0, 4'b0100, 2'b00, "R4 two-level freq");
    apply(2'd1, 2'd0, 0, 2'd0, 3'd0, 4'b1000, 2'b00, "R4/R2 two-level amp");
    apply(2'd3, 2'd1, 0, 2'd0, 3'b101, 4'b1011, 2'b00, "R5 four-level phase");
    apply(2'd2, 2'd1, 0, 2'd0, 3'b101, 4'b1001, 2'b00, "R5 four-level msb");
    apply(2'd0, 2'd0, 0, 2'd1, 3'd0, 4'b0100, 2'b00, "R7 ramp P2P3");
    apply(2'd0, 2'd0, 0, 2'd2, 3'd0, 4'b1000, 2'b00, "R7 ramp P3");
    apply(2'd1, 2'd1, 0, 2'd3, 3'b101, 4'b0110, 2'b10, "R8 serial ramp");

    // R1: latency from pin edge
    apply(2'd2, 2'd0, 0, 2'd0, 3'd0, 4'b0000, 2'b00, "R1 setup");
    pins = 4'b0100;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(c0f, w0(0), "R1 after two edges");
    @(posedge clk);
    @(negedge clk);
    chk(c0f, w0(1), "R1 after three edges");

    apply(2'd2, 2'd0, 1, 2'd0, 3'd0, 4'b0100, 2'b00, "R6 sweep");
    apply(2'd2, 2'd0, 0, 2'd0, 3'd0, 4'b0100, 2'b00, "R6 sticky");
    do_reset();
    apply(2'd1, 2'd2, 0, 2'd0, 3'd0, 4'b0100, 2'b00, "R6 eight-level");
    do_reset();
    apply(2'd3, 2'd1, 0, 2'd0, 3'b011, 4'b1111, 2'b00, "R6 bad pin map");
    do_reset();
    apply(2'd2, 2'd0, 0, 2'd1, 3'd0, 4'b1100, 2'b00, "R6 ramp conflict");
    do_reset();
    apply(2'd2, 2'd0, 0, 2'd0, 3'd0, 4'b0100, 2'b00, "R6 cleared by reset");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule